// File: doc/BRIEF.md
# Fragment depth and alpha test unit

This block decides, for each fragment in a pixel pipeline, whether the fragment survives and whether its depth should be written back. It holds two 16-bit configuration registers. One controls the depth test: an enable bit, a comparison function and an update enable. The other controls the alpha test: an 8-bit threshold and a comparison function. Both tests use the same 3-bit code for the eight comparison functions.

Each fragment brings three values: its own 24-bit depth, the 24-bit depth already stored at its position, and its 8-bit alpha. They arrive on a valid/ready handshake. The decision appears one cycle after the fragment is accepted, as a registered pass flag and a depth write-enable. The block does not touch framebuffer storage or colour.

Top module: `frag_test_unit`

## Requirements
- R1: After reset, both configuration registers read 0, `out_valid_o` is 0 and `in_ready_o` is 1. With the reset configuration, every fragment is killed and no depth write is issued.
- R2: A write with `cfg_sel_i`=0 loads the depth register. A write with `cfg_sel_i`=1 loads the alpha-mode register. `cfg_rdata_o` returns the register chosen by `cfg_sel_i`. Depth register bits 15:5 and alpha-mode bits 15:11 read as zero.
- R3: Depth register layout: bit 0 enables the depth test, bits 3:1 hold the function, bit 4 enables the depth update. The function codes are 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. The comparison is applied as (incoming depth op stored depth), unsigned, 24 bits.
- R4: While bit 0 of the depth register is 0, the depth test passes whatever the depth values are, and `out_zwrite_o` stays 0.
- R5: Alpha-mode layout: bits 7:0 hold the threshold and bits 10:8 hold the function, with the same codes as R3. The test is (fragment alpha op threshold), unsigned 8-bit.
- R6: `out_pass_o` is 1 exactly when both the depth test and the alpha test pass.
- R7: `out_zwrite_o` is 1 exactly when the depth test is enabled, the depth update is enabled and `out_pass_o` is 1.
- R8: A fragment is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both 1. Its result is presented with `out_valid_o`=1 from the next cycle. `in_ready_o` is 1 when no result is held or `out_ready_i` is 1. A result held with `out_ready_i`=0 stays unchanged.
- R9: The result is computed with the configuration in force when the fragment is accepted. Writing a register while a result is held does not change that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Register select: 0 depth, 1 alpha-mode |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Selected register contents |
| in_valid_i | input | 1 | Fragment valid |
| in_ready_o | output | 1 | Fragment can be accepted |
| frag_z_i | input | ZW | Incoming fragment depth |
| stored_z_i | input | ZW | Stored depth at the fragment position |
| frag_alpha_i | input | 8 | Fragment alpha |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream takes the result |
| out_pass_o | output | 1 | Fragment survives both tests |
| out_zwrite_o | output | 1 | Write the incoming depth |

## Verification
The assertions assume that the fragment inputs and the configuration write port are stable around each rising edge. They also assume that `out_ready_i` is a level the downstream holds for the whole cycle. The bench changes every input on the falling edge, so each edge sees settled values. Configuration writes are made only while no fragment is being offered, except in the stall case, where a write is issued on purpose while a result is held. The sweep covers all eight functions for both tests, both enable bits, and the less, equal and greater relations, including operands with the top bit set.

// File: rtl/fragtest_pkg.sv
package fragtest_pkg;
  localparam int CFG_W    = 16;
  localparam int ALPHA_W  = 8;
  localparam int FN_W     = 3;
  localparam int ZCFG_W   = 2 + FN_W;
  localparam int AMODE_W  = ALPHA_W + FN_W;

  typedef enum logic [FN_W-1:0] {
    CMP_NEVER  = 3'd0,
    CMP_LT     = 3'd1,
    CMP_EQ     = 3'd2,
    CMP_LE     = 3'd3,
    CMP_GT     = 3'd4,
    CMP_NE     = 3'd5,
    CMP_GE     = 3'd6,
    CMP_ALWAYS = 3'd7
  } cmp_fn_e;

  // bit 4 update, bits 3:1 function, bit 0 test enable
  typedef struct packed {
    logic    upd;
    cmp_fn_e fn;
    logic    en;
  } zcfg_t;

  // bits 10:8 function, bits 7:0 threshold
  typedef struct packed {
    cmp_fn_e            fn;
    logic [ALPHA_W-1:0] thr;
  } amode_t;
endpackage

// File: rtl/frag_cmp.sv
module frag_cmp
  import fragtest_pkg::*;
#(
  parameter int W = 8
) (
  input  cmp_fn_e        fn_i,
  input  logic [W-1:0]   lhs_i,
  input  logic [W-1:0]   rhs_i,
  output logic           res_o
);
  logic lt, eq;

  always_comb begin
    lt = lhs_i < rhs_i;
    eq = lhs_i == rhs_i;
    unique case (fn_i)
      CMP_NEVER:  res_o = 1'b0;
      CMP_LT:     res_o = lt;
      CMP_EQ:     res_o = eq;
      CMP_LE:     res_o = lt | eq;
      CMP_GT:     res_o = ~(lt | eq);
      CMP_NE:     res_o = ~eq;
      CMP_GE:     res_o = ~lt;
      default:    res_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/frag_cfg_regs.sv
module frag_cfg_regs
  import fragtest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output zcfg_t            zcfg_o,
  output amode_t           amode_o
);
  zcfg_t  zcfg_q, zcfg_d;
  amode_t amode_q, amode_d;
  logic   z_en, a_en;

  always_comb begin
    z_en    = we_i & ~sel_i;
    a_en    = we_i &  sel_i;
    zcfg_d  = zcfg_t'(wdata_i[ZCFG_W-1:0]);
    amode_d = amode_t'(wdata_i[AMODE_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zcfg_q  <= '0;
      amode_q <= '0;
    end else begin
      if (z_en) zcfg_q  <= zcfg_d;
      if (a_en) amode_q <= amode_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o[AMODE_W-1:0] = amode_q;
    else       rdata_o[ZCFG_W-1:0]  = zcfg_q;
  end

  assign zcfg_o  = zcfg_q;
  assign amode_o = amode_q;

  p_zcfg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i) |=> (zcfg_o == $past(wdata_i[ZCFG_W-1:0])));
  p_amode_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |=> (amode_o == $past(wdata_i[AMODE_W-1:0])));
endmodule

// File: rtl/frag_test_unit.sv
module frag_test_unit
  import fragtest_pkg::*;
#(
  parameter int ZW = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [ZW-1:0]      frag_z_i,
  input  logic [ZW-1:0]      stored_z_i,
  input  logic [ALPHA_W-1:0] frag_alpha_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               out_pass_o,
  output logic               out_zwrite_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q, rst_sync_d;
  logic              rst_int_n;

  always_comb rst_sync_d = {rst_sync_q[SYNC_N-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= rst_sync_d;
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  zcfg_t  zcfg;
  amode_t amode;

  frag_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .zcfg_o  (zcfg),
    .amode_o (amode)
  );

  logic z_cmp, a_cmp;

  frag_cmp #(.W(ZW)) u_zcmp (
    .fn_i  (zcfg.fn),
    .lhs_i (frag_z_i),
    .rhs_i (stored_z_i),
    .res_o (z_cmp)
  );

  frag_cmp #(.W(ALPHA_W)) u_acmp (
    .fn_i  (amode.fn),
    .lhs_i (frag_alpha_i),
    .rhs_i (amode.thr),
    .res_o (a_cmp)
  );

  logic z_ok, pass_d, zw_d, accept, load_en;
  logic valid_d, valid_q, pass_q, zw_q;

  always_comb begin
    z_ok       = ~zcfg.en | z_cmp;
    pass_d     = z_ok & a_cmp;
    zw_d       = zcfg.en & zcfg.upd & pass_d;
    in_ready_o = ~valid_q | out_ready_i;
    accept     = in_valid_i & in_ready_o;
    load_en    = accept;
    valid_d    = accept | (valid_q & ~out_ready_i);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
      zw_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        pass_q <= pass_d;
        zw_q   <= zw_d;
      end
    end
  end

  assign out_valid_o  = valid_q;
  assign out_pass_o   = pass_q;
  assign out_zwrite_o = zw_q;

  p_accept_shows_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (in_valid_i && in_ready_o) |=> out_valid_o);
  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable({out_pass_o, out_zwrite_o})));
  p_zoff_nowrite_r4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (in_valid_i && in_ready_o && !zcfg.en) |=> !out_zwrite_o);
  p_alpha_never_r5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (in_valid_i && in_ready_o && amode.fn == CMP_NEVER) |=> !out_pass_o);
  p_write_needs_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (out_valid_o && out_zwrite_o) |-> out_pass_o);
endmodule

// File: tb/test_frag_test_unit.sv
module test_frag_test_unit;
  localparam int ZW = 24;
  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        in_valid, in_ready, out_valid, out_ready, out_pass, out_zwrite;
  logic [ZW-1:0] fz, sz;
  logic [7:0]  fa;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  frag_test_unit #(.ZW(ZW)) i_frag_test_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .frag_z_i(fz), .stored_z_i(sz), .frag_alpha_i(fa),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_pass_o(out_pass), .out_zwrite_o(out_zwrite)
  );

  function automatic bit ref_cmp(input int fn, input longint a, input longint b);
    case (fn)
      0: return 0;
      1: return a < b;
      2: return a == b;
      3: return a <= b;
      4: return a > b;
      5: return a != b;
      6: return a >= b;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  // send one fragment with downstream ready, check result, drain
  task automatic send(input logic [ZW-1:0] z, input logic [ZW-1:0] s, input logic [7:0] a,
                      input bit ep, input bit ew, input string req);
    @(negedge clk);
    fz = z; sz = s; fa = a; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, out_valid, 1);
    chk({req, " pass"}, out_pass, ep);
    chk({req, " zwrite"}, out_zwrite, ew);
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [ZW-1:0] zp [4][2];
    logic [7:0] ap [4];
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; in_valid = 0; out_ready = 1;
    fz = '0; sz = '0; fa = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    rd(0, rv); chk("R1 zreg", rv, 0);
    rd(1, rv); chk("R1 areg", rv, 0);
    send(24'd5, 24'd9, 8'hFF, 0, 0, "R1 reset kill");

    // R2 write/read with reserved bits
    wr(0, 16'hFFFF); rd(0, rv); chk("R2 zreg", rv, 16'h001F);
    wr(1, 16'hFFFF); rd(1, rv); chk("R2 areg", rv, 16'h07FF);
    rd(0, rv); chk("R2 zreg kept", rv, 16'h001F);
    wr(0, 16'h1234); rd(0, rv); chk("R2 zreg 2", rv, 16'h0014);

    zp[0][0] = 24'd100;      zp[0][1] = 24'd200;
    zp[1][0] = 24'd200;      zp[1][1] = 24'd200;
    zp[2][0] = 24'd300;      zp[2][1] = 24'd200;
    zp[3][0] = 24'hFFFFFF;   zp[3][1] = 24'h000001;
    ap[0] = 8'h10; ap[1] = 8'h80; ap[2] = 8'hFF; ap[3] = 8'h7F;

    // R3..R7 sweep
    for (int zf = 0; zf < 8; zf++) begin
      for (int en = 0; en < 2; en++) begin
        for (int up = 0; up < 2; up++) begin
          wr(0, 16'(up * 16 + zf * 2 + en));
          for (int af = 0; af < 8; af++) begin
            wr(1, 16'(af * 256 + 8'h80));
            for (int zi = 0; zi < 4; zi++) begin
              for (int ai = 0; ai < 4; ai++) begin
                bit zok, aok, p, w;
                zok = (en == 0) || ref_cmp(zf, zp[zi][0], zp[zi][1]);
                aok = ref_cmp(af, ap[ai], 8'h80);
                p = zok && aok;
                w = (en == 1) && (up == 1) && p;
                send(zp[zi][0], zp[zi][1], ap[ai], p, w,
                     en == 0 ? "R4 R6 R7 zoff" :
                     (af == 7 ? "R3 R6 R7 depth" : "R5 R6 R7 alpha"));
              end
            end
          end
        end
      end
    end

    // R8 R9 stall and hold
    wr(0, 16'h0017);          // enable, fn 3 (le), update
    wr(1, 16'h0700);          // alpha always
    @(negedge clk);
    fz = 24'd1; sz = 24'd2; fa = 8'h00; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid after accept", out_valid, 1);
    chk("R8 ready low while held", in_ready, 0);
    chk("R8 held pass", out_pass, 1);
    wr(1, 16'h0000);          // alpha never while held
    wr(0, 16'h0000);
    chk("R9 pass unchanged", out_pass, 1);
    chk("R9 zwrite unchanged", out_zwrite, 1);
    chk("R8 still valid", out_valid, 1);
    out_ready = 1'b1;
    #1 chk("R8 ready with out_ready", in_ready, 1);
    @(negedge clk);
    chk("R8 drained", out_valid, 0);
    send(24'd1, 24'd2, 8'h00, 0, 0, "R9 new config applies");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule